// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for an 8-bit successive-approximation converter that reads one of eight analog inputs. A start request latches a channel number and two clock-rate fields. The block then drives the input multiplexer select and a track/hold control, and presents a trial code to an external comparator and DAC. It reads back one comparator decision per step and at the end publishes the final code with a completion flag and a one-cycle interrupt pulse.

Each conversion lasts a fixed number of conversion-clock periods. The conversion clock is an enable derived from the system clock. A CPU-rate field and a fast-select bit pick its rate. The first periods form the sampling window. The remaining periods are shared equally among the bit decisions, MSB first, and any leftover periods form a short tail before the result is latched. With the default parameters a conversion takes 160 periods: a 12-period sampling window, eight decisions of 18 periods each, and a 4-period tail.

Top module: `sar_seq_ctrl`

## Requirements
- R1: When `start_i` is high at a clock edge and `busy_o` is low, the conversion starts. From the next cycle `busy_o` and `sample_o` are high and `chan_o` shows the value that `chan_i` had at that edge.
- R2: While `busy_o` is high, `start_i`, `chan_i`, `cpu_div_i` and `fast_sel_i` have no effect. `chan_o`, the timing and the result stay as set at the start, and no second conversion follows.
- R3: The conversion-clock divisor is set by `cpu_div_i` and `fast_sel_i`. With `cpu_div_i`=00 it is 2 (fast 0) or 1 (fast 1). With 01 it is 4 or 2. With 11 it is 16 or 8. The reserved code 10 behaves like 11.
- R4: `busy_o` stays high for exactly 160×divisor cycles. `sample_o` is high for the first 12×divisor of those cycles.
- R5: The approximation runs MSB first. A bit under test is kept when `comp_i`=1 (input at or above the trial code) and cleared otherwise. With a comparator that reports input ≥ trial, the result equals the input level, and both 00h and FFh are reachable.
- R6: `result_o` changes only in the cycle where `irq_o` is high. `irq_o` lasts one cycle and comes in the cycle after `busy_o` falls. `done_o` is high from that cycle until the next accepted start.
- R7: After reset `busy_o`, `sample_o`, `done_o` and `irq_o` are 0 and `result_o` is 00h.
- R8: `trial_o` holds 80h from the start through the sampling window and the first decision step. It first changes 30×divisor cycles after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled each edge |
| chan_i | input | 3 | Requested analog channel |
| cpu_div_i | input | 2 | CPU-rate field of the rate table |
| fast_sel_i | input | 1 | Selects the faster conversion-clock column |
| comp_i | input | 1 | Comparator: 1 when input ≥ trial code |
| chan_o | output | 3 | Multiplexer select held for the conversion |
| sample_o | output | 1 | Track/hold control, high while sampling |
| trial_o | output | 8 | Trial code to the DAC |
| busy_o | output | 1 | Conversion in progress |
| result_o | output | 8 | Last completed result |
| done_o | output | 1 | A result is available since the last start |
| irq_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `comp_i` is a settled function of `trial_o` and `chan_o` within the same cycle. They also assume that reset is held low from time zero for some cycles. The bench meets the first assumption with a combinational comparator model. It reads a fixed level table indexed by `chan_o` and compares the level against `trial_o`, so no stale decision is ever fed back. Requests and field changes during a conversion are made on purpose, because the design must ignore them. The bench drives all inputs on the falling edge, away from the sampling edge.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SAMPLE = 2'd1,
      PH_DECIDE = 2'd2,
      PH_TAIL   = 2'd3
   } sar_phase_t;

   // divisor of the system clock that gives one conversion-clock period
   function automatic int unsigned rate_divisor(logic [1:0] cpu_rate, logic fast);
      int unsigned base;
      case (cpu_rate)
         2'b00:   base = 2;
         2'b01:   base = 4;
         default: base = 16;   // 10 is reserved and folded onto 11
      endcase
      return fast ? base / 2 : base;
   endfunction

   function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/sar_rate_sel.sv
module sar_rate_sel #(
   parameter int unsigned DIV_W = 4
) (
   input  logic [1:0]       cpu_div_i,
   input  logic             fast_sel_i,
   output logic [DIV_W-1:0] div_m1_o
);
   import sar_seq_pkg::*;

   if (DIV_W < 4) begin : g_bad_width
      $error("sar_rate_sel: DIV_W must hold a divisor of 16");
   end

   always_comb begin
      div_m1_o = DIV_W'(rate_divisor(cpu_div_i, fast_sel_i) - 1);
   end

endmodule

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
   parameter int unsigned DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [DIV_W-1:0] div_m1_i,
   input  logic             run_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] lim_q;

   assign tick_o = run_i && (cnt_q == lim_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= '0;
      end else if (load_i) begin
         cnt_q <= '0;
         lim_q <= div_m1_i;
      end else if (run_i) begin
         cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/sar_step_engine.sv
module sar_step_engine #(
   parameter int unsigned RES      = 8,
   parameter int unsigned CONV_P   = 160,
   parameter int unsigned SAMPLE_P = 12
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           accept_i,
   input  logic           tick_i,
   input  logic           comp_i,
   output logic           busy_o,
   output logic           sample_o,
   output logic [RES-1:0] trial_o,
   output logic [RES-1:0] result_o,
   output logic           done_o,
   output logic           irq_o
);
   import sar_seq_pkg::*;

   localparam int unsigned STEP_P = (CONV_P - SAMPLE_P) / RES;
   localparam int unsigned TAIL_P = CONV_P - SAMPLE_P - STEP_P * RES;
   localparam int unsigned CMAX   = max3(SAMPLE_P, STEP_P, TAIL_P);
   localparam int unsigned CW     = $clog2(CMAX + 1);
   localparam int unsigned BW     = $clog2(RES);
   localparam logic [CW-1:0] SAMPLE_LAST = CW'(SAMPLE_P - 1);
   localparam logic [CW-1:0] STEP_LAST   = CW'(STEP_P - 1);
   localparam logic [CW-1:0] TAIL_LAST   = CW'((TAIL_P == 0) ? 0 : TAIL_P - 1);
   localparam logic [RES-1:0] MSB_ONE    = {1'b1, {(RES-1){1'b0}}};
   localparam logic [RES-1:0] LSB_ONE    = {{(RES-1){1'b0}}, 1'b1};

   if (STEP_P < 1) begin : g_bad_step
      $error("sar_step_engine: too few periods for the decisions");
   end
   if (SAMPLE_P < 1) begin : g_bad_sample
      $error("sar_step_engine: sampling window must be at least one period");
   end

   sar_phase_t     ph_q;
   logic [CW-1:0]  cnt_q;
   logic [BW-1:0]  bidx_q;
   logic [RES-1:0] work_q;
   logic [RES-1:0] res_q;
   logic [RES-1:0] mask;
   logic [RES-1:0] work_dec;
   logic           irq_q;
   logic           done_q;

   // decision on the bit under test, then arm the next lower bit
   always_comb begin
      mask     = LSB_ONE << bidx_q;
      work_dec = (comp_i ? work_q : (work_q & ~mask)) | (mask >> 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         bidx_q <= '0;
         work_q <= '0;
         res_q  <= '0;
         irq_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         case (ph_q)
            PH_IDLE: begin
               if (accept_i) begin
                  ph_q   <= PH_SAMPLE;
                  cnt_q  <= '0;
                  bidx_q <= BW'(RES - 1);
                  work_q <= MSB_ONE;
                  done_q <= 1'b0;
               end
            end
            PH_SAMPLE: begin
               if (tick_i) begin
                  if (cnt_q == SAMPLE_LAST) begin
                     ph_q  <= PH_DECIDE;
                     cnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            PH_DECIDE: begin
               if (tick_i) begin
                  if (cnt_q == STEP_LAST) begin
                     cnt_q  <= '0;
                     work_q <= work_dec;
                     if (bidx_q != '0) begin
                        bidx_q <= bidx_q - 1'b1;
                     end else if (TAIL_P == 0) begin
                        ph_q   <= PH_IDLE;
                        res_q  <= work_dec;
                        irq_q  <= 1'b1;
                        done_q <= 1'b1;
                     end else begin
                        ph_q <= PH_TAIL;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            PH_TAIL: begin
               if (tick_i) begin
                  if (cnt_q == TAIL_LAST) begin
                     ph_q   <= PH_IDLE;
                     res_q  <= work_q;
                     irq_q  <= 1'b1;
                     done_q <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign busy_o   = (ph_q != PH_IDLE);
   assign sample_o = (ph_q == PH_SAMPLE);
   assign trial_o  = work_q;
   assign result_o = res_q;
   assign done_o   = done_q;
   assign irq_o    = irq_q;

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
   parameter int unsigned RES      = 8,
   parameter int unsigned CHW      = 3,
   parameter int unsigned CONV_P   = 160,
   parameter int unsigned SAMPLE_P = 12,
   parameter int unsigned DIV_W    = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic [CHW-1:0] chan_i,
   input  logic [1:0]     cpu_div_i,
   input  logic           fast_sel_i,
   input  logic           comp_i,
   output logic [CHW-1:0] chan_o,
   output logic           sample_o,
   output logic [RES-1:0] trial_o,
   output logic           busy_o,
   output logic [RES-1:0] result_o,
   output logic           done_o,
   output logic           irq_o
);

   if (RES < 2) begin : g_bad_res
      $error("sar_seq_ctrl: resolution must be at least 2 bits");
   end
   if (CONV_P < SAMPLE_P + RES) begin : g_bad_conv
      $error("sar_seq_ctrl: conversion shorter than sampling plus decisions");
   end

   logic             accept;
   logic             tick;
   logic [DIV_W-1:0] div_m1;
   logic [CHW-1:0]   chan_q;

   assign accept = start_i && !busy_o;

   sar_rate_sel #(.DIV_W(DIV_W)) u_rate (
      .cpu_div_i (cpu_div_i),
      .fast_sel_i(fast_sel_i),
      .div_m1_o  (div_m1)
   );

   sar_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (accept),
      .div_m1_i(div_m1),
      .run_i   (busy_o),
      .tick_o  (tick)
   );

   sar_step_engine #(
      .RES     (RES),
      .CONV_P  (CONV_P),
      .SAMPLE_P(SAMPLE_P)
   ) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept_i(accept),
      .tick_i  (tick),
      .comp_i  (comp_i),
      .busy_o  (busy_o),
      .sample_o(sample_o),
      .trial_o (trial_o),
      .result_o(result_o),
      .done_o  (done_o),
      .irq_o   (irq_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      chan_q <= '0;
      else if (accept) chan_q <= chan_i;
   end

   assign chan_o = chan_q;

endmodule

// File: rtl/sar_seq_checker.sv
module sar_seq_checker #(
   parameter int unsigned RES = 8,
   parameter int unsigned CHW = 3
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start_i,
   input logic [CHW-1:0] chan_i,
   input logic [CHW-1:0] chan_o,
   input logic           sample_o,
   input logic [RES-1:0] trial_o,
   input logic           busy_o,
   input logic [RES-1:0] result_o,
   input logic           done_o,
   input logic           irq_o
);
   localparam logic [RES-1:0] MSB_ONE = {1'b1, {(RES-1){1'b0}}};

   a_r1_start_enters_sample: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && sample_o && chan_o == $past(chan_i)));

   a_r2_chan_held: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> (!busy_o || $stable(chan_o)));

   a_r4_sample_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
      sample_o |-> busy_o);

   a_r8_trial_msb_while_sampling: assert property (@(posedge clk) disable iff (!rst_n)
      sample_o |-> (trial_o == MSB_ONE));

   a_r6_result_moves_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result_o) |-> irq_o);

   a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   a_r6_irq_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (irq_o && done_o));

   a_r6_irq_only_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $fell(busy_o));

endmodule

bind sar_seq_ctrl sar_seq_checker #(.RES(RES), .CHW(CHW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .chan_i  (chan_i),
   .chan_o  (chan_o),
   .sample_o(sample_o),
   .trial_o (trial_o),
   .busy_o  (busy_o),
   .result_o(result_o),
   .done_o  (done_o),
   .irq_o   (irq_o)
);

// File: tb/sar_seq_ctrl_test.sv
module sar_seq_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [2:0] chan_i = 3'd0;
   logic [1:0] cpu_div_i = 2'b00;
   logic       fast_sel_i = 1'b0;
   logic       comp_i;
   logic [2:0] chan_o;
   logic       sample_o;
   logic [7:0] trial_o;
   logic       busy_o;
   logic [7:0] result_o;
   logic       done_o;
   logic       irq_o;

   always #10 clk = ~clk;

   logic [7:0] lvl [8];
   assign comp_i = (lvl[chan_o] >= trial_o);

   sar_seq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
      .cpu_div_i(cpu_div_i), .fast_sel_i(fast_sel_i), .comp_i(comp_i),
      .chan_o(chan_o), .sample_o(sample_o), .trial_o(trial_o),
      .busy_o(busy_o), .result_o(result_o), .done_o(done_o), .irq_o(irq_o)
   );

   typedef struct {
      logic [7:0]  res;
      int unsigned div;
      logic [2:0]  ch;
   } exp_t;

   exp_t q[$];
   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   task automatic chk(bit ok, string req, string what, int act, int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   function automatic int unsigned divof(logic [1:0] c, logic f);
      int unsigned b;
      b = (c == 2'b00) ? 2 : (c == 2'b01) ? 4 : 16;
      return f ? b / 2 : b;
   endfunction

   // monitor: counts cycles of each conversion, pops and compares on irq
   int unsigned bcnt = 0, scnt = 0, hcnt = 0;
   bit tchg = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (busy_o) begin
            bcnt++;
            if (sample_o) scnt++;
            if (!tchg) begin
               if (trial_o == 8'h80) hcnt++;
               else tchg = 1'b1;
            end
            chk(q.size() != 0 && chan_o == q[0].ch, "R2", "chan_o during conversion",
                chan_o, (q.size() != 0) ? q[0].ch : 0);
         end
         if (irq_o) begin
            if (q.size() == 0) begin
               chk(1'b0, "R2", "unexpected result", result_o, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(result_o == e.res, "R5", "result", result_o, e.res);
               chk(bcnt == 160 * e.div, "R4", "busy cycles", bcnt, 160 * e.div);
               chk(scnt == 12 * e.div, "R4", "sample cycles", scnt, 12 * e.div);
               chk(hcnt == 30 * e.div, "R8", "trial 80h hold", hcnt, 30 * e.div);
               chk(done_o == 1'b1, "R6", "done with irq", done_o, 1);
            end
            bcnt = 0; scnt = 0; hcnt = 0; tchg = 1'b0;
         end
      end
   end

   task automatic conv(logic [2:0] ch, logic [1:0] c, logic f, bit disturb);
      exp_t e;
      e.res = lvl[ch];
      e.div = divof(c, f);
      e.ch  = ch;
      q.push_back(e);
      @(negedge clk);
      start_i = 1'b1; chan_i = ch; cpu_div_i = c; fast_sel_i = f;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o && sample_o && chan_o == ch, "R1", "start accepted", {busy_o, sample_o, chan_o}, {2'b11, ch});
      chk(done_o == 1'b0, "R6", "done cleared by start", done_o, 0);
      if (disturb) begin
         repeat (40) @(negedge clk);
         start_i = 1'b1; chan_i = ch + 3'd3; cpu_div_i = 2'b00; fast_sel_i = ~f;
         @(negedge clk);
         start_i = 1'b0;
      end
      while (busy_o) @(negedge clk);
      @(negedge clk);
      chk(done_o == 1'b1 && irq_o == 1'b0, "R6", "done held, irq dropped", {done_o, irq_o}, 2'b10);
   endtask

   initial begin
      lvl[0] = 8'h00; lvl[1] = 8'hFF; lvl[2] = 8'h80; lvl[3] = 8'h7F;
      lvl[4] = 8'h55; lvl[5] = 8'hAA; lvl[6] = 8'h01; lvl[7] = 8'hFE;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R7 reset state
      chk(!busy_o && !sample_o && !done_o && !irq_o && result_o == 8'h00, "R7", "reset state",
          {busy_o, sample_o, done_o, irq_o, result_o}, 0);

      conv(3'd0, 2'b00, 1'b1, 1'b0);   // R3 div 1, R5 code 00h
      conv(3'd1, 2'b00, 1'b0, 1'b0);   // R3 div 2, R5 code FFh
      conv(3'd2, 2'b01, 1'b1, 1'b1);   // R2 disturbed, div 2
      repeat (20) @(negedge clk);
      chk(!busy_o && q.size() == 0, "R2", "no conversion from ignored start", busy_o, 0);
      conv(3'd3, 2'b01, 1'b0, 1'b0);   // R3 div 4
      conv(3'd4, 2'b11, 1'b1, 1'b0);   // R3 div 8
      conv(3'd5, 2'b10, 1'b0, 1'b0);   // R3 reserved code acts as div 16
      conv(3'd6, 2'b11, 1'b0, 1'b1);   // R3 div 16, R2 disturbed
      repeat (20) @(negedge clk);
      chk(!busy_o && q.size() == 0, "R2", "no second conversion", busy_o, 0);
      conv(3'd7, 2'b00, 1'b1, 1'b0);

      chk(q.size() == 0, "R6", "all results delivered", q.size(), 0);
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule